// File: doc/BRIEF.md
# Differential 8-Phase Symbol Decoder

The block sits behind a phase extractor in an 8-phase differential PSK receiver. For each symbol it receives one quantized carrier phase as an unsigned word with a valid strobe. It subtracts the phase of the previous symbol, wrapping modulo one full turn, because the data is carried only by the change in phase. It then removes the constellation's 22.5 degree rotation and decides which of eight equal sectors the change falls in. The sector index passes through a Gray table, so a one-sector decision error corrupts only one bit. The result is a registered 3-bit symbol.

A run-time control can swap the outer two bits of each symbol. With it, the output matches either the specified bit order or the reversed order that some demodulator chains produce. The first strobe after reset, or after a clear, only captures a reference phase and produces no output. Throughput is one symbol per clock, far above the nominal 10500 symbols (31500 bits) per second. Carrier recovery, timing recovery, pulse shaping and phase extraction are done elsewhere.

Top module: `dpsk8_symbol_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, `sym_valid_o` is 0 and `sym_o` is 0.
- R2: The first accepted phase after reset produces no output symbol. It only stores the reference phase.
- R3: Every later accepted phase makes `sym_valid_o` high for exactly the one cycle that follows the accepting clock edge. `sym_valid_o` is low in every other cycle.
- R4: The phase change is d = (phase_i − previous phase) mod 256, where 256 counts are one full turn. Two inputs with the same change give the same symbol, whatever their absolute phases.
- R5: The sector index is s = ((d − 16) mod 256) div 32. This removes the 16-count (22.5 degree) rotation. A change that lies exactly on a boundary, d = 16 + 32k, goes to sector k, the sector that begins there.
- R6: With reversal off, `sym_o` = s XOR (s >> 1). Bit 2 of `sym_o` is the most significant bit of that code, so neighbouring sectors differ in one bit.
- R7: When `reverse_i` is 1 in the accepting cycle, `sym_o[2]` and `sym_o[0]` of the code from R6 are exchanged. `sym_o[1]` is unchanged.
- R8: `sym_o` keeps its value in every cycle that does not follow an accepted phase.
- R9: While `clear_i` is high, no symbol is emitted for that cycle's input. The next accepted phase behaves as the first after reset. A phase that is accepted together with `clear_i` becomes the new reference.
- R10: Phases accepted on consecutive clock edges each produce a symbol, with no gaps, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_i | input | 1 | Drops the stored reference phase |
| phase_valid_i | input | 1 | Strobe: `phase_i` carries a new symbol phase |
| phase_i | input | 8 | Unsigned phase, 256 counts per turn |
| reverse_i | input | 1 | 1 swaps the outer two bits of the symbol |
| sym_valid_o | output | 1 | One-cycle strobe for a decoded symbol |
| sym_o | output | 3 | Decoded symbol, held between strobes |

## Verification
A wrong stored reference phase shows up in the very next emitted symbol, because that symbol's phase change is measured against it. Every later symbol then returns to normal, since each new phase replaces the reference. A stuck or stale reference-loaded flag shows at once, either as a strobe after the first phase or as a silent strobe after a clear. A wrong rotation offset, sector slice or Gray entry appears only for the phase changes that land in the affected sectors. For that reason every change value from 0 to 255 is swept, with each reversal setting.

// File: rtl/dpsk8_pkg.sv
package dpsk8_pkg;
   localparam int SYM_BITS = 3;
   localparam int SECTORS  = 1 << SYM_BITS;

   typedef logic [SYM_BITS-1:0] sym_t;

   // binary-reflected Gray code of a sector index
   function automatic sym_t sector_to_gray(input sym_t s);
      return s ^ (s >> 1);
   endfunction
endpackage

// File: rtl/dpsk8_phase_diff.sv
module dpsk8_phase_diff #(
   parameter int PHASE_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear_i,
   input  logic               valid_i,
   input  logic [PHASE_W-1:0] phase_i,
   output logic [PHASE_W-1:0] diff_o,
   output logic               fire_o,
   output logic               primed_o
);
   logic [PHASE_W-1:0] prev_q;
   logic               primed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q   <= '0;
         primed_q <= 1'b0;
      end else begin
         if (valid_i) begin
            prev_q   <= phase_i;
            primed_q <= 1'b1;
         end else if (clear_i) begin
            primed_q <= 1'b0;
         end
      end
   end

   // modulo-2^PHASE_W subtraction wraps naturally
   assign diff_o   = phase_i - prev_q;
   assign fire_o   = valid_i && primed_q && !clear_i;
   assign primed_o = primed_q;
endmodule

// File: rtl/dpsk8_sector_slicer.sv
module dpsk8_sector_slicer
   import dpsk8_pkg::*;
#(
   parameter int PHASE_W  = 8,
   parameter bit USE_GRAY = 1'b1
) (
   input  logic [PHASE_W-1:0] diff_i,
   input  logic               reverse_i,
   output sym_t               sym_o
);
   localparam int SECTOR_SHIFT = PHASE_W - SYM_BITS;
   localparam int ROT_COUNTS   = 1 << (SECTOR_SHIFT - 1);

   logic [PHASE_W-1:0] derotated;
   sym_t               sector;
   sym_t               code;
   sym_t               swapped;

   // lower edge of each sector is inclusive
   assign derotated = diff_i - PHASE_W'(ROT_COUNTS);
   assign sector    = derotated[PHASE_W-1 -: SYM_BITS];

   generate
      if (USE_GRAY) begin : g_gray
         assign code = sector_to_gray(sector);
      end else begin : g_natural
         assign code = sector;
      end
   endgenerate

   generate
      for (genvar b = 0; b < SYM_BITS; b++) begin : g_swap
         assign swapped[b] = code[SYM_BITS-1-b];
      end
   endgenerate

   assign sym_o = reverse_i ? swapped : code;

   always_comb begin
      if (USE_GRAY)
         a_r6_gray_adjacent: assert ($countones(sector_to_gray(sector) ^ sector_to_gray(sector + 3'd1)) == 1);
   end
endmodule

// File: rtl/dpsk8_out_stage.sv
module dpsk8_out_stage
   import dpsk8_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  sym_t sym_i,
   output logic valid_o,
   output sym_t sym_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         sym_o   <= '0;
      end else begin
         valid_o <= load_i;
         if (load_i) sym_o <= sym_i;
      end
   end
endmodule

// File: rtl/dpsk8_symbol_decoder.sv
module dpsk8_symbol_decoder
   import dpsk8_pkg::*;
#(
   parameter int PHASE_W  = 8,
   parameter bit USE_GRAY = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear_i,
   input  logic               phase_valid_i,
   input  logic [PHASE_W-1:0] phase_i,
   input  logic               reverse_i,
   output logic               sym_valid_o,
   output logic [2:0]         sym_o
);
   generate
      if (PHASE_W < SYM_BITS + 1) begin : g_bad_width
         $error("PHASE_W must leave room for the half-sector rotation");
      end
   endgenerate

   logic [PHASE_W-1:0] diff;
   logic               fire;
   logic               primed;
   sym_t               sliced;

   dpsk8_phase_diff #(.PHASE_W(PHASE_W)) u_diff (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (clear_i),
      .valid_i  (phase_valid_i),
      .phase_i  (phase_i),
      .diff_o   (diff),
      .fire_o   (fire),
      .primed_o (primed)
   );

   dpsk8_sector_slicer #(.PHASE_W(PHASE_W), .USE_GRAY(USE_GRAY)) u_slice (
      .diff_i    (diff),
      .reverse_i (reverse_i),
      .sym_o     (sliced)
   );

   dpsk8_out_stage u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (fire),
      .sym_i   (sliced),
      .valid_o (sym_valid_o),
      .sym_o   (sym_o)
   );

   a_r2_first_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_valid_i && !primed) |=> !sym_valid_o);

   a_r3_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_valid_i && primed && !clear_i) |=> sym_valid_o);

   a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !phase_valid_i |=> !sym_valid_o);

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !phase_valid_i |=> $stable(sym_o));

   a_r9_clear_silent: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> !sym_valid_o);

   a_r9_clear_rearms: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_i && !phase_valid_i) |=> !primed);
endmodule

// File: tb/test_dpsk8_symbol_decoder.sv
module test_dpsk8_symbol_decoder;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       clear_i;
   logic       phase_valid_i;
   logic [7:0] phase_i;
   logic       reverse_i;
   logic       sym_valid_o;
   logic [2:0] sym_o;

   int checks = 0;
   int errors = 0;

   logic [7:0] ref_prev;
   bit         ref_primed;

   always #2 clk = ~clk;

   dpsk8_symbol_decoder i_dpsk8_symbol_decoder (
      .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
      .phase_valid_i(phase_valid_i), .phase_i(phase_i), .reverse_i(reverse_i),
      .sym_valid_o(sym_valid_o), .sym_o(sym_o)
   );

   function automatic logic [2:0] expect_sym(input logic [7:0] d, input bit rev);
      logic [7:0] a = d - 8'd16;
      logic [2:0] s = a[7:5];
      logic [2:0] g = s ^ (s >> 1);
      return rev ? {g[0], g[1], g[2]} : g;
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // drive one phase; valid stays high until idle()
   task automatic send(input logic [7:0] ph, input bit rev, input string req);
      bit         fire;
      logic [2:0] e;
      @(negedge clk);
      phase_valid_i = 1'b1; phase_i = ph; reverse_i = rev;
      fire = ref_primed && !clear_i;
      e = expect_sym(ph - ref_prev, rev);
      ref_prev = ph; ref_primed = 1'b1;
      @(posedge clk); #1;
      check({req, " valid"}, {7'd0, sym_valid_o}, {7'd0, fire});
      if (fire) check({req, " symbol"}, {5'd0, sym_o}, {5'd0, e});
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      phase_valid_i = 1'b0; clear_i = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      rst_n = 1'b0; clear_i = 1'b0; phase_valid_i = 1'b0; phase_i = 8'h00; reverse_i = 1'b0;
      ref_prev = 8'h00; ref_primed = 1'b0;
      repeat (3) @(posedge clk);
      #1 check("R1 valid in reset", {7'd0, sym_valid_o}, 8'd0);
      check("R1 symbol in reset", {5'd0, sym_o}, 8'd0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 valid after reset", {7'd0, sym_valid_o}, 8'd0);
      check("R1 symbol after reset", {5'd0, sym_o}, 8'd0);
   endtask

   task automatic t_first_silent;
      send(8'd200, 1'b0, "R2 first phase");
      idle(1);
      send(8'd216, 1'b0, "R3 second phase"); // d=16 -> sector 0
      idle(0);
      @(posedge clk); #1;
      check("R3 strobe width", {7'd0, sym_valid_o}, 8'd0);
   endtask

   task automatic t_sweep(input bit rev);
      for (int d = 0; d < 256; d++) begin
         send(ref_prev + 8'(d), rev, rev ? "R7 sweep reversed" : "R5 R6 sweep");
         idle(0);
      end
   endtask

   task automatic t_absolute;
      logic [2:0] first_sym;
      send(8'd10, 1'b0, "R4 ref a");
      send(8'd110, 1'b0, "R4 change 100 a");
      first_sym = sym_o;
      send(8'd250, 1'b0, "R4 ref b");
      send(8'd94, 1'b0, "R4 change 100 wrapped"); // 94-250 = 100 mod 256
      check("R4 same change same symbol", {5'd0, sym_o}, {5'd0, first_sym});
      idle(0);
   endtask

   task automatic t_hold;
      logic [2:0] held;
      send(ref_prev + 8'd80, 1'b1, "R8 load");
      held = sym_o;
      idle(0);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         phase_i = 8'hA5; reverse_i = ~reverse_i;
         check("R8 held symbol", {5'd0, sym_o}, {5'd0, held});
         check("R3 no strobe while idle", {7'd0, sym_valid_o}, 8'd0);
      end
   endtask

   task automatic t_clear;
      // clear alone, then next phase is silent
      @(negedge clk); clear_i = 1'b1;
      @(negedge clk); clear_i = 1'b0; ref_primed = 1'b0;
      send(8'd40, 1'b0, "R9 after clear silent");
      send(8'd120, 1'b0, "R9 rearmed");
      // clear together with a phase: phase becomes reference, no output
      @(negedge clk); clear_i = 1'b1;
      send(8'd7, 1'b0, "R9 clear with phase");
      @(negedge clk); clear_i = 1'b0;
      send(8'd7 + 8'd176, 1'b0, "R9 uses new reference");
      idle(0);
   endtask

   task automatic t_stream;
      for (int i = 0; i < 40; i++)
         send(ref_prev + 8'((i * 37 + 5) & 255), i[0], "R10 back-to-back");
      idle(0);
      @(posedge clk); #1;
      check("R10 stream ends", {7'd0, sym_valid_o}, 8'd0);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_first_silent();
            t_sweep(1'b0);
            t_sweep(1'b1);
            t_absolute();
            t_hold();
            t_clear();
            t_stream();
         end
         begin
            repeat (20000) @(posedge clk);
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule